// File: doc/BRIEF.md
# Data-Fault Status Capture with Lock

This block sits beside a load/store pipeline and records what went wrong when a data access faults. On a fault it latches a status word, the faulting virtual address, and a page-table-entry address. The page-table-entry address is formed from a page-table base and the faulting page number. Each fault also produces a one-cycle vector selection, so the exception logic can steer the fetch to the right handler.

A lock keeps the first fault's record. The lock sets on capture. While it is set, later faults still produce vector selections but do not overwrite the record. Handler code reads the fault-address register last, and that read (`va_rd`) releases the lock.

Top module: `mfc_capture`

## Requirements
- R1: After reset, `stat_q`, `va_q`, `vform_q`, `locked`, `vec_valid` and `vec` are all zero.
- R2: A fault (`flt_valid`=1) seen while `locked`=0 loads `stat_q`, `va_q` and `vform_q` at the next clock edge and sets `locked`.
- R3: A fault seen while `locked`=1 leaves `stat_q`, `va_q` and `vform_q` unchanged.
- R4: `va_rd`=1 without a simultaneous unlocked fault clears `locked` at the next edge, so that a following fault is captured again.
- R5: `stat_q[15:5]` holds `flt_insn_hi`, which is the faulting instruction's bits 31..21 in the same order.
- R6: `stat_q[4:0]` is the fault code: bit0 is set for a store (`flt_write`=1). Bits 1 to 4 are one-hot on `flt_kind`, with the encodings 0 = access violation → bit1, 1 = bad address → bit2, 2 = fault-on-read → bit3, 3 = TLB miss → bit4.
- R7: With `fmt_sel`=0, `vform_q` = `pt_base` OR ((`flt_va` >> 13) << 3), truncated to 48 bits.
- R8: With `fmt_sel`=1, `vform_q` = `pt_base` OR (page-number bits [19:0] of `flt_va` >> 13, shifted left by 3).
- R9: One cycle after every fault, whether or not the lock is set, `vec_valid` pulses for exactly one cycle. `vec` is 1 for a TLB miss, 2 for a TLB miss with `flt_pte_ld`=1, and 0 for every other kind.
- R10: When an unlocked fault and `va_rd` arrive in the same cycle, the capture takes effect and `locked` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_valid | input | 1 | A data fault is reported this cycle |
| flt_kind | input | 2 | Fault kind (0 access violation, 1 bad address, 2 fault-on-read, 3 TLB miss) |
| flt_write | input | 1 | The faulting access was a store |
| flt_pte_ld | input | 1 | The faulting access was a firmware page-table-entry load |
| flt_insn_hi | input | 11 | Faulting instruction bits 31..21 |
| flt_va | input | 48 | Faulting virtual address |
| pt_base | input | 48 | Virtual page-table base |
| fmt_sel | input | 1 | Selects the formatted-address layout |
| va_rd | input | 1 | Fault-address register is being read (releases the lock) |
| stat_q | output | 16 | Captured status word |
| va_q | output | 48 | Captured fault virtual address |
| vform_q | output | 48 | Captured formatted page-table-entry address |
| locked | output | 1 | Capture lock |
| vec_valid | output | 1 | Vector selection valid (one-cycle pulse) |
| vec | output | 2 | Vector: 0 data fault, 1 data miss, 2 double miss |

## Verification
The bench checks the following corner cases:

- **Second fault while locked.** The bench sends a second fault with a different address. A design that ignores the lock would report the second address instead of the first.
- **Vector while locked.** The bench checks that the vector pulse still fires for the locked-out fault. A design that gates dispatch on the lock would lose the handler entry.
- **Capture and release together.** The bench sends an unlocked fault and a release read in the same cycle. A design that lets the read win would reopen the record to the next fault.
- **Double-miss steering and layouts.** The bench checks that a TLB miss on a page-table-entry load goes to the double-miss vector, and checks both address layouts. A swapped select or a wrong page-number truncation would show up in `vec` or `vform_q`.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
    typedef enum logic [1:0] {
        KIND_ACV  = 2'd0,
        KIND_BVA  = 2'd1,
        KIND_FOR  = 2'd2,
        KIND_TBM  = 2'd3
    } flt_kind_e;

    typedef enum logic [1:0] {
        VEC_DFAULT = 2'd0,
        VEC_DMISS  = 2'd1,
        VEC_DDMISS = 2'd2
    } vec_e;

    localparam int CODE_W  = 5;
    localparam int INSN_W  = 11;
    localparam int BIT_WR  = 0;
    localparam int BIT_ACV = 1;
    localparam int BIT_BVA = 2;
    localparam int BIT_FOR = 3;
    localparam int BIT_TBM = 4;
endpackage

// File: rtl/mfc_status_enc.sv
module mfc_status_enc
    import mfc_pkg::*;
#(
    parameter int STAT_W = CODE_W + INSN_W
) (
    input  logic [1:0]        kind,
    input  logic              is_write,
    input  logic [INSN_W-1:0] insn_hi,
    output logic [STAT_W-1:0] stat
);
    logic [CODE_W-1:0] code;

    always_comb begin
        code          = '0;
        code[BIT_WR]  = is_write;
        unique case (flt_kind_e'(kind))
            KIND_ACV: code[BIT_ACV] = 1'b1;
            KIND_BVA: code[BIT_BVA] = 1'b1;
            KIND_FOR: code[BIT_FOR] = 1'b1;
            KIND_TBM: code[BIT_TBM] = 1'b1;
            default:  code          = code;
        endcase
        stat = {insn_hi, code};
    end

    always_comb begin
        a_r6_kind_onehot: assert ($countones(code[BIT_TBM:BIT_ACV]) == 1)
            else $error("fault code kind bits not one-hot");
    end
endmodule

// File: rtl/mfc_va_format.sv
module mfc_va_format #(
    parameter int VA_W      = 48,
    parameter int PAGE_BITS = 13,
    parameter int PTE_SHIFT = 3,
    parameter int CVPN_W    = 20
) (
    input  logic [VA_W-1:0] va,
    input  logic [VA_W-1:0] base,
    input  logic            compact,
    output logic [VA_W-1:0] form
);
    logic [VA_W-1:0] vpn_full;
    logic [VA_W-1:0] field_lin;
    logic [VA_W-1:0] field_cmp;

    always_comb begin
        vpn_full  = va >> PAGE_BITS;
        field_lin = vpn_full << PTE_SHIFT;
        field_cmp = VA_W'(vpn_full[CVPN_W-1:0]) << PTE_SHIFT;
        form      = base | (compact ? field_cmp : field_lin);
    end
endmodule

// File: rtl/mfc_vec_sel.sv
module mfc_vec_sel
    import mfc_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       pte_ld,
    output logic [1:0] vec
);
    always_comb begin
        if (flt_kind_e'(kind) == KIND_TBM)
            vec = pte_ld ? VEC_DDMISS : VEC_DMISS;
        else
            vec = VEC_DFAULT;
    end
endmodule

// File: rtl/mfc_capture.sv
module mfc_capture
    import mfc_pkg::*;
#(
    parameter int VA_W      = 48,
    parameter int PAGE_BITS = 13,
    parameter int PTE_SHIFT = 3,
    parameter int CVPN_W    = 20,
    localparam int STAT_W   = CODE_W + INSN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_valid,
    input  logic [1:0]        flt_kind,
    input  logic              flt_write,
    input  logic              flt_pte_ld,
    input  logic [INSN_W-1:0] flt_insn_hi,
    input  logic [VA_W-1:0]   flt_va,
    input  logic [VA_W-1:0]   pt_base,
    input  logic              fmt_sel,
    input  logic              va_rd,
    output logic [STAT_W-1:0] stat_q,
    output logic [VA_W-1:0]   va_q,
    output logic [VA_W-1:0]   vform_q,
    output logic              locked,
    output logic              vec_valid,
    output logic [1:0]        vec
);
    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [VA_W-1:0]   va;
        logic [VA_W-1:0]   vform;
        logic              lock;
        logic              vvld;
        logic [1:0]        vsel;
    } state_t;

    state_t st_d, st_q;

    logic [STAT_W-1:0] stat_new;
    logic [VA_W-1:0]   form_new;
    logic [1:0]        vec_new;
    logic              capture;

    mfc_status_enc #(.STAT_W(STAT_W)) u_stat (
        .kind     (flt_kind),
        .is_write (flt_write),
        .insn_hi  (flt_insn_hi),
        .stat     (stat_new)
    );

    mfc_va_format #(
        .VA_W      (VA_W),
        .PAGE_BITS (PAGE_BITS),
        .PTE_SHIFT (PTE_SHIFT),
        .CVPN_W    (CVPN_W)
    ) u_fmt (
        .va      (flt_va),
        .base    (pt_base),
        .compact (fmt_sel),
        .form    (form_new)
    );

    mfc_vec_sel u_vec (
        .kind   (flt_kind),
        .pte_ld (flt_pte_ld),
        .vec    (vec_new)
    );

    always_comb begin
        st_d    = st_q;
        capture = flt_valid && !st_q.lock;
        if (capture) begin
            st_d.stat  = stat_new;
            st_d.va    = flt_va;
            st_d.vform = form_new;
            st_d.lock  = 1'b1;
        end else if (va_rd) begin
            st_d.lock  = 1'b0;
        end
        st_d.vvld = flt_valid;
        st_d.vsel = flt_valid ? vec_new : 2'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_q    = st_q.stat;
    assign va_q      = st_q.va;
    assign vform_q   = st_q.vform;
    assign locked    = st_q.lock;
    assign vec_valid = st_q.vvld;
    assign vec       = st_q.vsel;

    a_r2_lock_sets: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid && !locked |=> locked && (va_q == $past(flt_va)));
    a_r3_hold_va: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid && locked |=> $stable(va_q) && $stable(stat_q) && $stable(vform_q));
    a_r4_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        va_rd && (locked || !flt_valid) |=> !locked);
    a_r10_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid && !locked && va_rd |=> locked);
    a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> vec_valid);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_valid |=> !vec_valid);
    a_r9_legal_vec: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> vec != 2'd3);
endmodule

// File: tb/mfc_capture_tb.sv
`timescale 1ns/1ps
module mfc_capture_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flt_valid = 1'b0;
    logic [1:0]  flt_kind = '0;
    logic        flt_write = 1'b0;
    logic        flt_pte_ld = 1'b0;
    logic [10:0] flt_insn_hi = '0;
    logic [47:0] flt_va = '0;
    logic [47:0] pt_base = '0;
    logic        fmt_sel = 1'b0;
    logic        va_rd = 1'b0;
    logic [15:0] stat_q;
    logic [47:0] va_q;
    logic [47:0] vform_q;
    logic        locked;
    logic        vec_valid;
    logic [1:0]  vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mfc_capture u_dut (
        .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_kind(flt_kind),
        .flt_write(flt_write), .flt_pte_ld(flt_pte_ld), .flt_insn_hi(flt_insn_hi),
        .flt_va(flt_va), .pt_base(pt_base), .fmt_sel(fmt_sel), .va_rd(va_rd),
        .stat_q(stat_q), .va_q(va_q), .vform_q(vform_q), .locked(locked),
        .vec_valid(vec_valid), .vec(vec)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_stat(input logic [1:0] k, input logic w, input logic [10:0] ih);
        logic [4:0] c;
        c = {4'b0, w};
        c[k + 1] = 1'b1;
        return {ih, c};
    endfunction

    function automatic logic [47:0] exp_form(input logic [47:0] base, input logic [47:0] va, input logic cmp);
        logic [47:0] vpn;
        vpn = va >> 13;
        if (cmp) return base | (48'(vpn[19:0]) << 3);
        return base | (vpn << 3);
    endfunction

    // One fault (and optional read) for one cycle; results checked at the following negedge.
    task automatic drive(input logic v, input logic [1:0] k, input logic w, input logic p,
                         input logic [10:0] ih, input logic [47:0] a, input logic [47:0] b,
                         input logic f, input logic rd);
        @(negedge clk);
        flt_valid = v; flt_kind = k; flt_write = w; flt_pte_ld = p;
        flt_insn_hi = ih; flt_va = a; pt_base = b; fmt_sel = f; va_rd = rd;
        @(negedge clk);
        flt_valid = 1'b0; va_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 stat", stat_q, 0);
        chk("R1 va", va_q, 0);
        chk("R1 vform", vform_q, 0);
        chk("R1 locked", locked, 0);
        chk("R1 vec_valid", vec_valid, 0);
        chk("R1 vec", vec, 0);
    endtask

    task automatic t_first_capture();
        drive(1, 2'd0, 0, 0, 11'h5A3, 48'h1234_5678_9ABC, 48'hF000_0000_0000, 0, 0);
        chk("R2 va", va_q, 48'h1234_5678_9ABC);
        chk("R2 locked", locked, 1);
        chk("R5 R6 stat acv read", stat_q, exp_stat(2'd0, 0, 11'h5A3));
        chk("R7 vform linear", vform_q, exp_form(48'hF000_0000_0000, 48'h1234_5678_9ABC, 0));
        chk("R9 vec_valid", vec_valid, 1);
        chk("R9 vec dfault", vec, 0);
    endtask

    task automatic t_locked_hold();
        drive(1, 2'd3, 1, 0, 11'h0FF, 48'hAAAA_BBBB_CCCC, 48'h0000_1111_0000, 1, 0);
        chk("R3 va held", va_q, 48'h1234_5678_9ABC);
        chk("R3 stat held", stat_q, exp_stat(2'd0, 0, 11'h5A3));
        chk("R3 vform held", vform_q, exp_form(48'hF000_0000_0000, 48'h1234_5678_9ABC, 0));
        chk("R9 vec while locked", {vec_valid, vec}, {1'b1, 2'd1});
        @(negedge clk);
        chk("R9 pulse one cycle", vec_valid, 0);
    endtask

    task automatic t_release_and_compact();
        drive(0, 2'd0, 0, 0, 0, 0, 0, 0, 1);
        chk("R4 lock cleared", locked, 0);
        drive(1, 2'd1, 1, 0, 11'h3C1, 48'hFEDC_BA98_7654, 48'h8000_0000_0000, 1, 0);
        chk("R4 recapture va", va_q, 48'hFEDC_BA98_7654);
        chk("R6 stat bva write", stat_q, exp_stat(2'd1, 1, 11'h3C1));
        chk("R8 vform compact", vform_q, exp_form(48'h8000_0000_0000, 48'hFEDC_BA98_7654, 1));
    endtask

    task automatic t_double_miss();
        drive(0, 2'd0, 0, 0, 0, 0, 0, 0, 1);
        drive(1, 2'd3, 0, 1, 11'h001, 48'h0000_0040_2000, 48'h0, 0, 0);
        chk("R9 vec ddmiss", vec, 2);
        chk("R6 stat tbm", stat_q, exp_stat(2'd3, 0, 11'h001));
    endtask

    task automatic t_simultaneous();
        drive(0, 2'd0, 0, 0, 0, 0, 0, 0, 1);
        drive(1, 2'd2, 1, 0, 11'h7FF, 48'h0BAD_F00D_0000, 48'h0, 0, 1);
        chk("R10 lock stays", locked, 1);
        chk("R10 captured", va_q, 48'h0BAD_F00D_0000);
        chk("R6 stat for write", stat_q, exp_stat(2'd2, 1, 11'h7FF));
        drive(1, 2'd0, 0, 0, 11'h000, 48'h1111_2222_3333, 48'h0, 0, 0);
        chk("R3 still held", va_q, 48'h0BAD_F00D_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_capture();
        t_locked_hold();
        t_release_and_compact();
        t_double_miss();
        t_simultaneous();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule